// File: doc/BRIEF.md
# Multi-Domain Scan Chain with Lockup Latches

This block is one scan chain assembled from several groups of scan flip-flops. Each group has its own clock pin and its own active edge, rising or falling. Every flop has a multiplexer in front of it. With shift mode off, the flop loads its own bit of the parallel functional input. With shift mode on, it loads the bit held by the flop before it in the chain.

The chain steps from one group into the next at a crossing. At each crossing the block either wires the two groups together directly or places a level-sensitive lockup element between them. The choice of element, its transparent level and the clock that drives it are all worked out at elaboration. They depend on the edges used on the two sides of the crossing and on whether the two groups share a clock domain. Because of this, shifting stays correct even when the clock of a capturing group arrives well after the clock of the group that launches into it.

Integrators set the number of groups, the length of each group, the active edge of each group, and the clock-domain and placement relation at each crossing. The chain is controlled only through its scan and functional ports.

Top module: `lockup_scan_chain`

## Requirements
- R1: An active-low asynchronous reset clears every flop at once, without waiting for a clock. While reset is low, all bits of func_q and scan_out read 0.
- R2: When scan_enable is 0, each flop loads its own bit of func_d at the active edge of its group's clock. func_q bit i is flop i, and flop 0 is the first flop after scan_in.
- R3: When scan_enable is 1, flop 0 loads scan_in and every other flop loads the flop before it in the chain. func_d has no effect in this mode.
- R4: All group clocks share one period, and the first and last groups use the rising edge. Under these conditions, a bit placed on scan_in just after the first group's rising edge of cycle k appears on scan_out in cycle k+NFLOP. The sample point is just before the last group's active edge.
- R5: Bit g of GRP_FALL selects the active edge of group g: 1 means the falling edge, 0 means the rising edge.
- R6: At a crossing where both groups use the rising edge, the lockup latch is transparent while the launching group's clock is low. That clock drives it.
- R7: At a crossing where both groups use the falling edge, the lockup latch is transparent while the launching group's clock is high. That clock drives it.
- R8: A crossing between groups of opposite edges gets no latch; it is a direct wire.
- R9: A same-edge crossing marked as lying inside one clock domain gets a latch only when its remote bit is set. Otherwise it is a direct wire.
- R10: Shifting delivers the pattern intact when each capturing group's clock lags its launching group's clock by any amount below half a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| seg_clk | input | NGRP | One clock per group of flops; bit g drives group g |
| rst_n | input | 1 | Active-low asynchronous reset of all flops |
| scan_enable | input | 1 | 1 selects the scan path, 0 selects functional data |
| scan_in | input | 1 | Serial input to flop 0 |
| func_d | input | NFLOP | Parallel functional inputs, bit i for flop i |
| func_q | output | NFLOP | Parallel flop outputs, bit i from flop i |
| scan_out | output | 1 | Output of the last flop in the chain |

## Verification
On every edge of every group clock, the embedded properties check three things: the reset clear, the load from func_d in functional mode, and the load from the predecessor in shift mode. On each closing edge, a lockup latch must also hold the value it was passing through. Properties cannot see whether a latch exists at the right crossings, whether its transparent level is right, or whether it is driven by the launching clock rather than the capturing one. Only the bench can show these, by running skewed clocks, streaming a long pattern and comparing scan_out with the pattern delayed by the flop count. The bench also sweeps functional patterns to cover parallel capture, and asserts reset in mid-cycle to show that the clear is asynchronous.

// File: rtl/lkchain_pkg.sv
`timescale 1ns/1ps
package lkchain_pkg;

   localparam int MAX_GRP = 8;

   typedef int grp_len_t [MAX_GRP];

   typedef enum logic [1:0] {
      XING_WIRE     = 2'd0,
      XING_LAT_LOW  = 2'd1,
      XING_LAT_HIGH = 2'd2
   } xing_kind_t;

   function automatic int chain_len(grp_len_t lens, int ngrp);
      int total = 0;
      for (int g = 0; g < ngrp; g++) total += lens[g];
      return total;
   endfunction

   function automatic int grp_base(grp_len_t lens, int grp);
      int base = 0;
      for (int g = 0; g < grp; g++) base += lens[g];
      return base;
   endfunction

   // Launch/capture edge pair decides whether hold margin already exists (R8);
   // same-domain crossings only get a latch when flagged remote (R9).
   function automatic xing_kind_t xing_kind(bit launch_fall, bit capture_fall,
                                            bit same_domain, bit remote);
      if (launch_fall != capture_fall) return XING_WIRE;
      if (same_domain && !remote)      return XING_WIRE;
      // latch must be open in the launching clock's inactive phase (R6, R7)
      return launch_fall ? XING_LAT_HIGH : XING_LAT_LOW;
   endfunction

endpackage

// File: rtl/lkchain_cell.sv
`timescale 1ns/1ps
module lkchain_cell #(
   parameter bit FALL_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic se,
   input  logic si,
   input  logic fd,
   output logic q
);

   logic nxt;
   assign nxt = se ? si : fd;

   generate
      if (FALL_EDGE) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= nxt;
         end

         p_reset_clear_r1: assert property (@(negedge clk) !rst_n |-> q == 1'b0)
            else $error("cell not cleared by reset");
         p_func_load_r2: assert property (@(negedge clk) disable iff (!rst_n)
            !se |=> q == $past(fd))
            else $error("functional load wrong");
         p_scan_load_r3: assert property (@(negedge clk) disable iff (!rst_n)
            se |=> q == $past(si))
            else $error("scan load wrong");
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= nxt;
         end

         p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> q == 1'b0)
            else $error("cell not cleared by reset");
         p_func_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !se |=> q == $past(fd))
            else $error("functional load wrong");
         p_scan_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
            se |=> q == $past(si))
            else $error("scan load wrong");
      end
   endgenerate

endmodule

// File: rtl/lkchain_segment.sv
`timescale 1ns/1ps
module lkchain_segment #(
   parameter int LEN       = 2,
   parameter bit FALL_EDGE = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           se,
   input  logic           si,
   input  logic [LEN-1:0] fd,
   output logic [LEN-1:0] fq,
   output logic           so
);

   logic [LEN:0] link;
   assign link[0] = si;

   generate
      for (genvar j = 0; j < LEN; j++) begin : g_cell
         lkchain_cell #(.FALL_EDGE(FALL_EDGE)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .se    (se),
            .si    (link[j]),
            .fd    (fd[j]),
            .q     (link[j+1])
         );
      end
   endgenerate

   assign fq = link[LEN:1];
   assign so = link[LEN];

endmodule

// File: rtl/lkchain_lockup.sv
`timescale 1ns/1ps
module lkchain_lockup #(
   parameter bit OPEN_HIGH = 1'b0
) (
   input  logic lclk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   // No reset: the latch refills from its source in its first open phase.
   always_latch begin
      if (lclk == OPEN_HIGH) q = d;
   end

   generate
      if (OPEN_HIGH) begin : g_open_high
         // closes on the falling edge, the same edge that launches new data (R7)
         p_close_hold_r7: assert property (@(negedge lclk) disable iff (!rst_n)
            q == d)
            else $error("latch did not carry old value at close");
      end else begin : g_open_low
         // closes on the rising edge, the same edge that launches new data (R6)
         p_close_hold_r6: assert property (@(posedge lclk) disable iff (!rst_n)
            q == d)
            else $error("latch did not carry old value at close");
      end
   endgenerate

endmodule

// File: rtl/lockup_scan_chain.sv
`timescale 1ns/1ps
module lockup_scan_chain
   import lkchain_pkg::*;
#(
   parameter int       NGRP      = 6,
   parameter grp_len_t GRP_LEN   = '{2, 2, 3, 2, 2, 3, 0, 0},
   parameter bit [NGRP-1:0] GRP_FALL  = 6'b011000,
   parameter bit [NGRP-1:0] SAME_DOM  = 6'b010010,
   parameter bit [NGRP-1:0] REMOTE    = 6'b010000,
   parameter int       NFLOP     = chain_len(GRP_LEN, NGRP)
) (
   input  logic [NGRP-1:0]  seg_clk,
   input  logic             rst_n,
   input  logic             scan_enable,
   input  logic             scan_in,
   input  logic [NFLOP-1:0] func_d,
   output logic [NFLOP-1:0] func_q,
   output logic             scan_out
);

   localparam int LAST = NGRP - 1;

   generate
      if (NGRP < 1 || NGRP > MAX_GRP) begin : g_bad_ngrp
         $error("NGRP out of range");
      end
      if (NFLOP != chain_len(GRP_LEN, NGRP)) begin : g_bad_nflop
         $error("NFLOP does not match the group lengths");
      end
   endgenerate

   logic grp_si [NGRP];
   logic grp_so [NGRP];

   assign grp_si[0] = scan_in;

   generate
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         localparam int BASE = grp_base(GRP_LEN, g);
         localparam int LEN  = GRP_LEN[g];

         if (LEN < 1) begin : g_bad_len
            $error("every group needs at least one flop");
         end

         lkchain_segment #(.LEN(LEN), .FALL_EDGE(GRP_FALL[g])) u_seg (
            .clk   (seg_clk[g]),
            .rst_n (rst_n),
            .se    (scan_enable),
            .si    (grp_si[g]),
            .fd    (func_d[BASE +: LEN]),
            .fq    (func_q[BASE +: LEN]),
            .so    (grp_so[g])
         );
      end

      for (genvar x = 1; x < NGRP; x++) begin : g_xing
         localparam xing_kind_t KIND =
            xing_kind(GRP_FALL[x-1], GRP_FALL[x], SAME_DOM[x], REMOTE[x]);

         if (KIND == XING_WIRE) begin : g_wire
            assign grp_si[x] = grp_so[x-1];
         end else begin : g_latch
            // clocked by the launching group, never the capturing one
            lkchain_lockup #(.OPEN_HIGH(KIND == XING_LAT_HIGH)) u_lat (
               .lclk  (seg_clk[x-1]),
               .rst_n (rst_n),
               .d     (grp_so[x-1]),
               .q     (grp_si[x])
            );
         end
      end
   endgenerate

   assign scan_out = grp_so[LAST];

endmodule

// File: tb/lockup_scan_chain_tb.sv
`timescale 1ns/1ps
module lockup_scan_chain_tb;
   import lkchain_pkg::*;

   localparam int CLK_PERIOD = 20;
   localparam int NGRP       = 6;
   localparam int NFLOP      = 14;
   localparam int STREAM_N   = 120;
   localparam grp_len_t LENS = '{2, 2, 3, 2, 2, 3, 0, 0};
   // capture clocks lag launch clocks, always below half a period (R10)
   localparam int SKEW [NGRP] = '{0, 0, 3, 5, 7, 9};

   logic [NGRP-1:0]  seg_clk;
   logic             rst_n;
   logic             scan_enable;
   logic             scan_in;
   logic [NFLOP-1:0] func_d;
   logic [NFLOP-1:0] func_q;
   logic             scan_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic stream_bits [STREAM_N];

   lockup_scan_chain #(
      .NGRP     (NGRP),
      .GRP_LEN  (LENS),
      .GRP_FALL (6'b011000),
      .SAME_DOM (6'b010010),
      .REMOTE   (6'b010000),
      .NFLOP    (NFLOP)
   ) u_dut (
      .seg_clk     (seg_clk),
      .rst_n       (rst_n),
      .scan_enable (scan_enable),
      .scan_in     (scan_in),
      .func_d      (func_d),
      .func_q      (func_q),
      .scan_out    (scan_out)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_clk
      logic ck = 1'b0;
      initial begin
         #(CLK_PERIOD + SKEW[g]);
         forever begin
            ck = 1'b1;
            #(CLK_PERIOD / 2);
            ck = 1'b0;
            #(CLK_PERIOD / 2);
         end
      end
      assign seg_clk[g] = ck;
   end

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge seg_clk[0]);
      #1;
   endtask

   task automatic capture(input logic [NFLOP-1:0] pat);
      step();
      scan_enable = 1'b0;
      func_d      = pat;
      step();
      step();
      check(32'(func_q), 32'(pat), "R2 functional capture");
   endtask

   initial begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int k = 0; k < STREAM_N; k++) begin
         if (k < 20)      stream_bits[k] = 1'(k % 2);
         else if (k < 35) stream_bits[k] = 1'b1;
         else if (k < 50) stream_bits[k] = 1'b0;
         else begin
            stream_bits[k] = lfsr[0];
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
         end
      end
   end

   initial begin
      rst_n       = 1'b0;
      scan_enable = 1'b0;
      scan_in     = 1'b0;
      func_d      = '0;
      repeat (3) step();
      // R1: state under reset
      check(32'(func_q), 32'd0, "R1 func_q under reset");
      check(32'(scan_out), 32'd0, "R1 scan_out under reset");
      rst_n = 1'b1;

      // R2: walking one, all ones, alternating
      for (int p = 0; p < NFLOP; p++) capture(NFLOP'(1) << p);
      capture('1);
      capture({(NFLOP/2){2'b10}});

      // R3,R4,R5,R6,R7,R8,R9,R10: stream through skewed groups
      step();
      scan_enable = 1'b1;
      for (int m = 0; m < STREAM_N + NFLOP; m++) begin
         if (m > 0) step();
         scan_in = (m < STREAM_N) ? stream_bits[m] : 1'b0;
         func_d  = func_d ^ NFLOP'(m * 37 + 5);
         #(SKEW[NGRP-1] - 2);
         if (m >= NFLOP)
            check(32'(scan_out), 32'(stream_bits[m - NFLOP]),
                  "R3,R4,R5,R6,R7,R8,R9,R10 scan stream");
      end

      // R1: asynchronous clear in mid-cycle after loading ones
      capture('1);
      rst_n = 1'b0;
      #1;
      check(32'(func_q), 32'd0, "R1 async clear func_q");
      check(32'(scan_out), 32'd0, "R1 async clear scan_out");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 2000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule